// File: doc/BRIEF.md
# Parallel EPROM Word-Read Sequencer

This block sits on the host side of a shared asynchronous parallel EPROM bus and turns a single-cycle read request into a correctly timed strobe sequence. Several 16-bit devices, each with 18 word-address lines, hang on the same data bus. The upper bits of the request address pick one device, whose own active-low chip-enable is driven low. A single active-low output-enable is shared by all devices and acts as the common read strobe. Deselected devices therefore stay in low-power standby.

All delays are derived from nanosecond parameters and the clock period, rounded up to whole cycles. Chip-enable and the address go out together. Output-enable follows after the access count minus the output-enable count, so the late strobe does not lengthen the access. The data word is sampled on the edge after the access window has fully run. Both strobes are then released together and returned with a one-cycle valid pulse. A float window follows before any device may be enabled again.

The sequencer has four states. IDLE goes to LEAD when a request is accepted. LEAD goes to READ when the lead wait expires, and output-enable falls at that point. READ goes to FLOAT when the read wait expires, which captures the data and releases the strobes. FLOAT goes back to IDLE when the float wait expires, and busy then drops. Requests are only taken in IDLE.

Top module: `eprom_rd_ctrl`

## Requirements
- R1: While reset is held, every chip-enable line and the output-enable line are high, the address bus is zero, and ack, busy and rd_valid are low.
- R2: An accepted request drives low exactly one chip-enable line, the one whose index equals req_addr[19:18]. At the same time it puts req_addr[17:0] on the address bus.
- R3: Output-enable falls exactly ACC_CYC-OE_CYC cycles after chip-enable falls. It is never low while all chip-enable lines are high.
- R4: rd_valid is a one-cycle pulse that rises ACC_CYC+1 cycles after chip-enable falls. rd_data carries the word the device drives at that time.
- R5: The address stays constant while output-enable is low. Chip-enable and output-enable return high on the same edge that raises rd_valid.
- R6: After the strobes are released, no chip-enable line falls again until DF_CYC+1 cycles have passed.
- R7: ack is a one-cycle pulse that is given only for a request seen while the block is idle. A request raised during a transfer is held off until the float window has ended.
- R8: Back-to-back reads to the same device or to different devices return words in request order, each matching the addressed location.
- R9: busy is high from the accepting edge until the float window ends, including the cycle of rd_valid.
- R10: The wait counts are ceil(ns / CLK_NS). The defaults are ACC_NS=100, OE_NS=50, DF_NS=35 and CLK_NS=10, which give ACC_CYC=10, OE_CYC=5 and DF_CYC=4. ACC_CYC must exceed OE_CYC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Read request, held until ack |
| req_addr | input | 20 | Device select (upper 2 bits) and word address (lower 18) |
| ack | output | 1 | One-cycle request accepted pulse |
| busy | output | 1 | Transfer or float window in progress |
| rd_valid | output | 1 | One-cycle returned-word pulse |
| rd_data | output | 16 | Returned word |
| mem_addr | output | 18 | Word address to the devices |
| mem_ce_n | output | 4 | Per-device active-low chip-enable |
| mem_oe_n | output | 1 | Shared active-low output-enable |
| mem_dq | input | 16 | Data bus from the devices |

## Verification
A wrong state or a miscounted timer shows at the strobe pins within one transfer. Output-enable then falls at the wrong offset, the capture happens while the device model still drives X, or the chip-enable of the next device falls inside the float window. A wrong decode gives two devices driving at once, and the model turns that into X on the returned word. An off-by-one in any wait count is caught by the cycle-accurate offset checks on the very first read.

// File: rtl/eprom_rd_pkg.sv
package eprom_rd_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_LEAD  = 2'd1,
        S_READ  = 2'd2,
        S_FLOAT = 2'd3
    } rd_state_t;

    function automatic int cdiv(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/eprom_wait_timer.sv
module eprom_wait_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/eprom_dev_decode.sv
module eprom_dev_decode #(
    parameter int SEL_W   = 2,
    parameter int NUM_DEV = 4
) (
    input  logic [SEL_W-1:0]   sel,
    output logic [NUM_DEV-1:0] ce_n
);
    for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
        assign ce_n[d] = (sel != SEL_W'(d));
    end
endmodule

// File: rtl/eprom_rd_ctrl.sv
module eprom_rd_ctrl
    import eprom_rd_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 18,
    parameter int SEL_W  = 2,
    parameter int CLK_NS = 10,
    parameter int ACC_NS = 100,
    parameter int OE_NS  = 50,
    parameter int DF_NS  = 35
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req,
    input  logic [ADDR_W+SEL_W-1:0]   req_addr,
    output logic                      ack,
    output logic                      busy,
    output logic                      rd_valid,
    output logic [DATA_W-1:0]         rd_data,
    output logic [ADDR_W-1:0]         mem_addr,
    output logic [(1<<SEL_W)-1:0]     mem_ce_n,
    output logic                      mem_oe_n,
    input  logic [DATA_W-1:0]         mem_dq
);
    localparam int NUM_DEV  = 1 << SEL_W;
    localparam int ACC_CYC  = cdiv(ACC_NS, CLK_NS);
    localparam int OE_CYC   = cdiv(OE_NS, CLK_NS);
    localparam int DF_CYC   = cdiv(DF_NS, CLK_NS);
    localparam int LEAD_CYC = ACC_CYC - OE_CYC;
    localparam int MAX_CYC  = (ACC_CYC > DF_CYC) ? ACC_CYC : DF_CYC;
    localparam int CNT_W    = $clog2(MAX_CYC + 1);
    localparam int GAP_W    = $clog2(DF_CYC + 1);

    rd_state_t            state, state_nx;
    logic                 tmr_load, tmr_done;
    logic [CNT_W-1:0]     tmr_val;
    logic [NUM_DEV-1:0]   sel_ce_n;

    eprom_dev_decode #(.SEL_W(SEL_W), .NUM_DEV(NUM_DEV)) dec_i (
        .sel  (req_addr[ADDR_W+SEL_W-1:ADDR_W]),
        .ce_n (sel_ce_n)
    );

    eprom_wait_timer #(.CNT_W(CNT_W)) tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // next state and timer reload
    always_comb begin
        state_nx = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state)
            S_IDLE: if (req) begin
                state_nx = S_LEAD;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(LEAD_CYC - 1);
            end
            S_LEAD: if (tmr_done) begin
                state_nx = S_READ;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(OE_CYC);
            end
            S_READ: if (tmr_done) begin
                state_nx = S_FLOAT;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(DF_CYC - 1);
            end
            S_FLOAT: if (tmr_done) state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack      <= 1'b0;
            busy     <= 1'b0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
            mem_addr <= '0;
            mem_ce_n <= '1;
            mem_oe_n <= 1'b1;
        end else begin
            ack      <= 1'b0;
            rd_valid <= 1'b0;
            unique case (state)
                S_IDLE: if (req) begin
                    ack      <= 1'b1;
                    busy     <= 1'b1;
                    mem_addr <= req_addr[ADDR_W-1:0];
                    mem_ce_n <= sel_ce_n;
                end
                S_LEAD: if (tmr_done) mem_oe_n <= 1'b0;
                S_READ: if (tmr_done) begin
                    rd_data  <= mem_dq;
                    rd_valid <= 1'b1;
                    mem_ce_n <= '1;
                    mem_oe_n <= 1'b1;
                end
                S_FLOAT: if (tmr_done) busy <= 1'b0;
                default: ;
            endcase
        end
    end

    // float-window observer for the gap assertion
    logic             any_ce;
    logic [GAP_W-1:0] gap_cnt;
    assign any_ce = ~&mem_ce_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     gap_cnt <= GAP_W'(DF_CYC);
        else if (any_ce)                gap_cnt <= '0;
        else if (gap_cnt < GAP_W'(DF_CYC)) gap_cnt <= gap_cnt + 1'b1;
    end

    p_one_device_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~mem_ce_n) <= 1);

    p_oe_under_ce_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> any_ce);

    p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n && $past(!mem_oe_n)) |-> $stable(mem_addr));

    p_joint_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> (&mem_ce_n && rd_valid));

    p_float_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (any_ce && !$past(any_ce)) |-> (gap_cnt >= GAP_W'(DF_CYC)));

    p_ack_from_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> ($past(!busy) && busy));

    p_busy_at_return_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> busy);
endmodule

// File: tb/eprom_rd_ctrl_tb.sv
module eprom_rd_ctrl_tb_top;
    localparam int NDEV = 4;
    localparam int ACC  = 10;   // ceil(100/10)
    localparam int OEC  = 5;    // ceil(50/10)
    localparam int DF   = 4;    // ceil(35/10)
    localparam int LEAD = ACC - OEC;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req;
    logic [19:0] req_addr;
    logic        ack, busy, rd_valid;
    logic [15:0] rd_data;
    logic [17:0] mem_addr;
    logic [3:0]  mem_ce_n;
    logic        mem_oe_n;
    logic [15:0] mem_dq;

    always #5 clk = ~clk;

    eprom_rd_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr),
        .ack(ack), .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_dq(mem_dq)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // device model: per-device contents, X until access delays pass, Z when not selected
    logic [15:0] mem [NDEV][64];
    int ce_age [NDEV];
    int oe_age;

    initial begin
        for (int d = 0; d < NDEV; d++)
            for (int a = 0; a < 64; a++)
                mem[d][a] = 16'((d * 16'h1357) ^ (a * 16'h0C1D) ^ 16'hA5A5);
    end

    always @(posedge clk) begin
        for (int d = 0; d < NDEV; d++)
            ce_age[d] <= mem_ce_n[d] ? 0 : ce_age[d] + 1;
        oe_age <= mem_oe_n ? 0 : oe_age + 1;
    end

    always_comb begin
        int drivers;
        drivers = 0;
        mem_dq  = 'z;
        for (int d = 0; d < NDEV; d++) begin
            if (!mem_ce_n[d] && !mem_oe_n) begin
                drivers++;
                if (ce_age[d] >= ACC && oe_age >= OEC) mem_dq = mem[d][mem_addr[5:0]];
                else                                   mem_dq = 'x;
            end
        end
        if (drivers > 1) mem_dq = 'x;
    end

    // scoreboard queues
    logic [15:0] exp_data [$];
    int          exp_dev  [$];

    task automatic do_read(input int dev, input logic [17:0] a);
        @(negedge clk);
        exp_data.push_back(mem[dev][a[5:0]]);
        exp_dev.push_back(dev);
        req      = 1'b1;
        req_addr = {2'(dev), a};
        do @(negedge clk); while (!ack);
        check(exp_data.size() == 1, "R7 ack with no transfer outstanding",
              exp_data.size(), 1);
        req = 1'b0;
    endtask

    // monitor
    int  cyc = 0;
    int  ce_fall_cyc = -1000;
    int  release_cyc = -1000;
    logic prev_any_ce = 1'b0;
    logic prev_oe_n   = 1'b1;
    logic [17:0] acc_addr;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if ((mem_ce_n != 4'hF) && !prev_any_ce) begin
                int dv;
                ce_fall_cyc = cyc;
                dv = (exp_dev.size() > 0) ? exp_dev.pop_front() : -1;
                check(dv >= 0 && mem_ce_n == ~(4'b1 << dv), "R2 single decoded enable",
                      mem_ce_n, ~(4'b1 << dv));
                check(cyc - release_cyc >= DF + 1, "R6 float gap",
                      cyc - release_cyc, DF + 1);
                acc_addr = mem_addr;
            end
            if (!mem_oe_n && prev_oe_n) begin
                check(cyc - ce_fall_cyc == LEAD, "R3 output-enable offset",
                      cyc - ce_fall_cyc, LEAD);
                check(mem_addr == acc_addr, "R5 address held", mem_addr, acc_addr);
            end
            if (rd_valid) begin
                logic [15:0] e;
                e = (exp_data.size() > 0) ? exp_data.pop_front() : 16'hxxxx;
                check(rd_data === e, "R8 returned word", rd_data, e);
                check(cyc - ce_fall_cyc == ACC + 1, "R4 capture offset",
                      cyc - ce_fall_cyc, ACC + 1);
                check(mem_ce_n == 4'hF && mem_oe_n, "R5 joint release",
                      {mem_ce_n, mem_oe_n}, 5'h1F);
                check(busy, "R9 busy at return", busy, 1);
                release_cyc = cyc;
            end
            if (ack) check(busy, "R9 busy on accept", busy, 1);
            prev_any_ce = (mem_ce_n != 4'hF);
            prev_oe_n   = mem_oe_n;
        end
    end

    // stimulus
    initial begin
        rst_n = 1'b0; req = 1'b0; req_addr = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(mem_ce_n == 4'hF && mem_oe_n, "R1 strobes idle", {mem_ce_n, mem_oe_n}, 5'h1F);
        check(mem_addr == 18'd0, "R1 address zero", mem_addr, 0);
        check(!ack && !busy && !rd_valid, "R1 handshake idle", {ack, busy, rd_valid}, 0);
        rst_n = 1'b1;
        // one read per device (R10 default timing drives the offset checks)
        for (int d = 0; d < NDEV; d++) do_read(d, 18'(d * 7 + 3));
        // same device back to back, then alternating devices
        do_read(2, 18'h3FFC0);
        do_read(2, 18'h0003F);
        for (int i = 0; i < 8; i++) do_read(i % 2 ? 3 : 0, 18'(i * 5 + 11));
        // request held through a transfer and the float window (R7)
        do_read(1, 18'h12345);
        @(negedge clk);
        exp_data.push_back(mem[0][6'h21]);
        exp_dev.push_back(0);
        req = 1'b1; req_addr = {2'd0, 18'h00021};
        repeat (3) @(negedge clk);
        check(!ack, "R7 no ack while busy", ack, 0);
        do @(negedge clk); while (!ack);
        req = 1'b0;
        wait (exp_data.size() == 0);
        repeat (DF + 3) @(negedge clk);
        check(!busy && mem_ce_n == 4'hF, "R9 idle after float", {busy, mem_ce_n}, 5'h0F);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog expired actual=%0d expected=0", exp_data.size());
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule